// File: doc/BRIEF.md
# Locked Paged Flash Window

This block lets a host see serial flash through a 256-byte window. Two byte registers select which 256-byte page of a 24-bit flash address space the window maps. A read request makes the block run a standard SPI read frame at the mapped page and return the bytes one by one. A write burst into the window programs that page. The block sends a write-enable frame, then a page-program frame carrying the address and the data, and then polls the flash status register until the device is no longer busy.

Programming is fenced by a write gate. The page can be programmed only after a fixed six-byte key has been written, in order, to the gate register. Writing zero to the gate locks it again. A burst that arrives while the gate is locked, or whose leading offset byte is not zero, is discarded and raises a sticky error flag. A separate register holds the SPI side in reset. A status byte shows which phase of a program operation is running and whether the gate is open.

Top module: `page_window_flash`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, busy is 0, err is 0, status is 0x00, and the gate is locked.
- R2: A register write to offset 0x8e sets flash address bits 15:8 and one to offset 0x8f sets bits 23:16. Bits 7:0 are always 0. A read request with rd_len = N-1 sends opcode 0x03 and then the three address bytes, most significant first. It then returns exactly N bytes (1 to 256) on rd_valid/rd_data, in ascending address order.
- R3: A window write burst is a run of win_wr bytes ended by win_last. The first byte is an offset that must be 0x00, and 1 to 256 data bytes follow it. The data bytes are programmed at consecutive addresses starting from the page base.
- R4: A program operation sends 0x06 in a frame of its own. It then sends 0x02 with three address bytes and the data in a second frame. After that it sends two-byte frames of 0x05, one after another, until bit 0 of the returned status byte is 0. busy then falls.
- R5: Writing 0xaa, 0x55, 0x50, 0x41, 0x52 and 0x44 to the gate register (offset 0xda), in that order, opens the gate. status bit 6 reads 1 while the gate is open.
- R6: A byte that breaks the key order sends the key matcher back to its start. A breaking byte equal to 0xaa counts as the first byte of a new key.
- R7: Writing 0x00 to the gate register closes the gate.
- R8: A window burst that starts while the gate is closed produces no SPI frame and leaves the flash unchanged. It sets err, and err stays set until reset.
- R9: A window burst whose offset byte is not 0x00 is discarded with no SPI frame, and it sets err.
- R10: Writing a value with bit 5 set to offset 0x82 holds the SPI side in reset. While held, spi_cs_n stays 1 and read requests and bursts are ignored. Writing 0x00 releases the hold.
- R11: status bit 0 is 1 while the write-enable and page-program frames are in progress, and bit 1 is 1 while status polling runs. The two bits are never 1 together, and bits 5:2 read 0.
- R12: SPI runs in mode 0. SCLK idles low and is low whenever spi_cs_n is high. MOSI carries the most significant bit first and is stable while SCLK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| win_wr | input | 1 | Window burst byte valid |
| win_data | input | 8 | Window burst byte |
| win_last | input | 1 | Marks the final byte of a burst |
| rd_req | input | 1 | Start a window read |
| rd_len | input | 8 | Number of bytes to read, minus one |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | An operation is in progress |
| status | output | 8 | Program phase and gate-open status |
| err | output | 1 | Sticky dropped-burst flag |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The case that is hardest to reach from the ports is key matching that recovers midway. For the gate to open, a broken key must be followed by a byte that starts a new key. The stimulus breaks the key with an unrelated byte and then with a repeated 0xaa, and checks status bit 6 after each attempt. Status polling that goes through several busy rounds is produced by a bench flash responder that reports busy for three polls after each program. Random page numbers, lengths and data are mixed with full-page and single-byte bursts, and each program is read back through the window.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

    localparam logic [7:0] REG_PAGE_LO = 8'h8E;
    localparam logic [7:0] REG_PAGE_HI = 8'h8F;
    localparam logic [7:0] REG_GATE    = 8'hDA;
    localparam logic [7:0] REG_SPI_RST = 8'h82;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_READ = 8'h03;

    localparam int KEY_LEN = 6;

    function automatic logic [7:0] key_byte(input logic [2:0] i);
        case (i)
            3'd0:    return 8'hAA;
            3'd1:    return 8'h55;
            3'd2:    return 8'h50;
            3'd3:    return 8'h41;
            3'd4:    return 8'h52;
            3'd5:    return 8'h44;
            default: return 8'h00;
        endcase
    endfunction

    typedef enum logic [3:0] {
        S_IDLE, S_FILL, S_DROP, S_WREN, S_GAP_W,
        S_PROG, S_GAP_P, S_POLL, S_READ
    } seq_st_e;

    typedef struct packed {
        logic [2:0] step;
        logic       open;
    } gate_st_t;

    typedef struct packed {
        logic       act;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] rx;
    } shift_st_t;

endpackage

// File: rtl/pwf_unlock.sv
module pwf_unlock
    import pwf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_wr,
    input  logic [7:0] gate_data,
    output logic       unlocked
);

    gate_st_t q, d;

    always_comb begin
        d = q;
        if (gate_wr) begin
            if (gate_data == 8'h00) begin
                d.open = 1'b0;
                d.step = '0;
            end else if (!q.open) begin
                if (gate_data == key_byte(q.step)) begin
                    if (q.step == 3'(KEY_LEN - 1)) begin
                        d.open = 1'b1;
                        d.step = '0;
                    end else begin
                        d.step = q.step + 3'd1;
                    end
                end else if (gate_data == key_byte(3'd0)) begin
                    d.step = 3'd1;
                end else begin
                    d.step = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign unlocked = q.open;

    AST_GATE_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_wr && gate_data == 8'h00) |=> !unlocked); // R7

    AST_OPEN_ON_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(gate_wr && gate_data == 8'h44)); // R5

endmodule

// File: rtl/pwf_spi_shift.sv
module pwf_spi_shift
    import pwf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi
);

    shift_st_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.act = 1'b0;
            d.cnt = '0;
        end else if (!q.act) begin
            if (start) begin
                d.act = 1'b1;
                d.cnt = '0;
                d.sh  = tx;
            end
        end else begin
            d.cnt = q.cnt + 4'd1;
            if (q.cnt[0]) begin
                d.sh = {q.sh[6:0], 1'b0};
                d.rx = {q.rx[6:0], miso};
            end
            if (q.cnt == 4'd15) d.act = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.act && (q.cnt == 4'd15);
    assign rx   = {q.rx[6:0], miso};
    assign sclk = q.act && q.cnt[0];
    assign mosi = q.sh[7];

    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(q.act)) |-> $stable(mosi)); // R12

endmodule

// File: rtl/pwf_page_buf.sv
module pwf_page_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/page_window_flash.sv
module page_window_flash
    import pwf_pkg::*;
#(
    parameter int PAGE_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       win_wr,
    input  logic [7:0] win_data,
    input  logic       win_last,
    input  logic       rd_req,
    input  logic [7:0] rd_len,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic [7:0] status,
    output logic       err,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    localparam int CNT_W = $clog2(PAGE_BYTES);
    localparam int IDX_W = CNT_W + 1;

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W:0]   n;
        logic [7:0]       pg_lo;
        logic [7:0]       pg_hi;
        logic             hold;
        logic             err;
    } ctl_t;

    ctl_t q, d;

    logic             unlocked;
    logic             sh_start, sh_done;
    logic [7:0]       sh_tx, sh_rx;
    logic             buf_we;
    logic [CNT_W-1:0] buf_waddr, buf_raddr;
    logic [7:0]       buf_rdata;
    logic [IDX_W-1:0] last_idx;

    pwf_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_wr   (reg_wr && reg_addr == REG_GATE),
        .gate_data (reg_wdata),
        .unlocked  (unlocked)
    );

    pwf_spi_shift u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q.hold),
        .start (sh_start),
        .tx    (sh_tx),
        .miso  (spi_miso),
        .done  (sh_done),
        .rx    (sh_rx),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi)
    );

    pwf_page_buf #(.DEPTH(PAGE_BYTES), .AW(CNT_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (win_data),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    // header bytes shared by program and read frames
    function automatic logic [7:0] hdr_byte(input logic [1:0] i, input logic [7:0] op,
                                            input logic [7:0] hi, input logic [7:0] lo);
        case (i)
            2'd0:    return op;
            2'd1:    return hi;
            2'd2:    return lo;
            default: return 8'h00;
        endcase
    endfunction

    assign last_idx  = IDX_W'(q.n) + IDX_W'(3);
    assign buf_raddr = CNT_W'(q.idx - IDX_W'(4));
    assign buf_waddr = CNT_W'(q.idx);

    always_comb begin
        d        = q;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        buf_we   = 1'b0;

        if (reg_wr) begin
            case (reg_addr)
                REG_PAGE_LO: d.pg_lo = reg_wdata;
                REG_PAGE_HI: d.pg_hi = reg_wdata;
                REG_SPI_RST: d.hold  = reg_wdata[5];
                default: ;
            endcase
        end

        case (q.st)
            S_IDLE: begin
                if (!q.hold) begin
                    if (win_wr) begin
                        d.idx = '0;
                        if (!unlocked || win_data != 8'h00) begin
                            d.err = 1'b1;
                            d.st  = win_last ? S_IDLE : S_DROP;
                        end else begin
                            d.st  = win_last ? S_IDLE : S_FILL;
                        end
                    end else if (rd_req) begin
                        d.st  = S_READ;
                        d.idx = '0;
                        d.n   = {1'b0, rd_len} + {{CNT_W{1'b0}}, 1'b1};
                    end
                end
            end
            S_FILL: begin
                if (win_wr) begin
                    buf_we = 1'b1;
                    d.idx  = q.idx + IDX_W'(1);
                    if (win_last || q.idx == IDX_W'(PAGE_BYTES - 1)) begin
                        d.n   = q.idx + IDX_W'(1);
                        d.idx = '0;
                        d.st  = S_WREN;
                    end
                end
            end
            S_DROP: begin
                if (win_wr && win_last) d.st = S_IDLE;
            end
            S_WREN: begin
                sh_start = 1'b1;
                sh_tx    = OP_WREN;
                if (sh_done) d.st = S_GAP_W;
            end
            S_GAP_W: begin
                d.st  = S_PROG;
                d.idx = '0;
            end
            S_PROG: begin
                sh_start = 1'b1;
                sh_tx    = (q.idx < IDX_W'(4)) ? hdr_byte(q.idx[1:0], OP_PROG, q.pg_hi, q.pg_lo)
                                               : buf_rdata;
                if (sh_done) begin
                    if (q.idx == last_idx) d.st = S_GAP_P;
                    else                   d.idx = q.idx + IDX_W'(1);
                end
            end
            S_GAP_P: begin
                d.st  = S_POLL;
                d.idx = '0;
            end
            S_POLL: begin
                sh_start = 1'b1;
                sh_tx    = (q.idx == '0) ? OP_RDSR : 8'h00;
                if (sh_done) begin
                    if (q.idx == '0) d.idx = IDX_W'(1);
                    else             d.st  = sh_rx[0] ? S_GAP_P : S_IDLE;
                end
            end
            S_READ: begin
                sh_start = 1'b1;
                sh_tx    = (q.idx < IDX_W'(4)) ? hdr_byte(q.idx[1:0], OP_READ, q.pg_hi, q.pg_lo)
                                               : 8'h00;
                if (sh_done) begin
                    if (q.idx == last_idx) d.st = S_IDLE;
                    else                   d.idx = q.idx + IDX_W'(1);
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (q.hold) d.st = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_cs_n = !(q.st == S_WREN || q.st == S_PROG || q.st == S_POLL || q.st == S_READ);
    assign busy     = (q.st != S_IDLE);
    assign err      = q.err;
    assign rd_valid = (q.st == S_READ) && sh_done && (q.idx >= IDX_W'(4));
    assign rd_data  = sh_rx;
    assign status   = {1'b0, unlocked, 4'b0000,
                       (q.st == S_GAP_P || q.st == S_POLL),
                       (q.st == S_WREN || q.st == S_GAP_W || q.st == S_PROG)};

    AST_LOCKED_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && win_wr && !q.hold && !unlocked) |=> (q.st != S_FILL)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R8

    AST_HOLD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold |=> spi_cs_n); // R10

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[1:0])); // R11

    AST_SCLK_LOW_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R12

endmodule

// File: tb/page_window_flash_tb.sv
module page_window_flash_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       win_wr = 1'b0;
    logic [7:0] win_data = '0;
    logic       win_last = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_len = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       busy;
    logic [7:0] status;
    logic       err;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    page_window_flash u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .win_wr(win_wr), .win_data(win_data),
        .win_last(win_last), .rd_req(rd_req), .rd_len(rd_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .status(status),
        .err(err), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash responder ----------------
    logic [7:0]  fmem [int];
    logic [7:0]  flog [1024];
    int          nframes = 0;
    int          npoll = 0;
    int          bitc = 0;
    int          bytec = 0;
    int          busy_left = 0;
    bit          wel = 0;
    bit          in_frame = 0;
    logic [7:0]  op = '0;
    logic [7:0]  inb = '0;
    logic [7:0]  outb = '0;
    logic [23:0] fa = '0;
    logic [23:0] last_addr = '0;

    function automatic logic [7:0] fget(input logic [23:0] a);
        return fmem.exists(int'(a)) ? fmem[int'(a)] : 8'hFF;
    endfunction

    task automatic take_byte(input logic [7:0] b);
        if (bytec == 0) begin
            op = b;
            if (b == 8'h05) begin
                outb = {7'b0, busy_left != 0};
                if (busy_left > 0) busy_left--;
                npoll++;
            end
        end else if (bytec <= 3) begin
            fa = {fa[15:0], b};
            if (bytec == 3) begin
                last_addr = fa;
                if (op == 8'h03) outb = fget(fa);
            end
        end else begin
            if (op == 8'h02 && wel)
                fmem[int'({fa[23:8], fa[7:0] + 8'(bytec - 4)})] = b;
            if (op == 8'h03) begin
                fa   = fa + 24'd1;
                outb = fget(fa);
            end
        end
    endtask

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (in_frame) begin
                if (nframes < 1024) flog[nframes] = op;
                nframes++;
                if (op == 8'h06) wel = 1;
                if (op == 8'h02 && wel) begin
                    wel = 0;
                    busy_left = 3;
                end
            end
            in_frame = 0; bitc = 0; bytec = 0; outb = '0;
        end else begin
            in_frame = 1;
            inb = {inb[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                take_byte(inb);
                bytec++;
            end
        end
    end

    always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = outb[7 - bitc];

    // ---------------- status monitor ----------------
    bit seen0 = 0, seen1 = 0, both = 0, hi_bits = 0;
    always @(negedge clk) if (rst_n) begin
        if (status[0]) seen0 = 1;
        if (status[1]) seen1 = 1;
        if (status[0] && status[1]) both = 1;
        if (status[5:2] != 4'b0) hi_bits = 1;
    end

    // ---------------- bench model and helpers ----------------
    logic [7:0] exp_mem [int];
    logic [7:0] wbuf [256];
    logic [7:0] rbuf [300];
    int         rcount;

    function automatic logic [7:0] eget(input logic [23:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; reg_wr = 0; win_wr = 0; win_last = 0; rd_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic send_key();
        reg_write(8'hDA, 8'hAA); reg_write(8'hDA, 8'h55); reg_write(8'hDA, 8'h50);
        reg_write(8'hDA, 8'h41); reg_write(8'hDA, 8'h52); reg_write(8'hDA, 8'h44);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic set_page(input logic [7:0] hi, input logic [7:0] lo);
        reg_write(8'h8F, hi);
        reg_write(8'h8E, lo);
    endtask

    task automatic win_burst(input logic [7:0] off, input int n);
        @(negedge clk);
        win_wr = 1; win_data = off; win_last = (n == 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            win_data = wbuf[i]; win_last = (i == n - 1);
        end
        @(negedge clk);
        win_wr = 0; win_last = 0;
        wait_idle();
    endtask

    task automatic do_read(input logic [7:0] hi, input logic [7:0] lo, input int n);
        set_page(hi, lo);
        @(negedge clk);
        rd_req = 1; rd_len = 8'(n - 1);
        @(negedge clk);
        rd_req = 0;
        rcount = 0;
        while (busy) begin
            if (rd_valid && rcount < 300) begin
                rbuf[rcount] = rd_data;
                rcount++;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_read(input logic [7:0] hi, input logic [7:0] lo, input int n,
                              input string req);
        bit ok = 1;
        int bad_i = 0;
        do_read(hi, lo, n);
        chk(rcount == n, req, rcount, n);
        for (int i = 0; i < n && i < rcount; i++) begin
            if (ok && rbuf[i] !== eget({hi, lo, 8'(i)})) begin
                ok = 0; bad_i = i;
            end
        end
        chk(ok, req, int'(rbuf[bad_i]), int'(eget({hi, lo, 8'(bad_i)})));
    endtask

    task automatic prog_page(input logic [7:0] hi, input logic [7:0] lo, input int n);
        int f0, p0;
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        set_page(hi, lo);
        f0 = nframes; p0 = npoll;
        win_burst(8'h00, n);
        for (int i = 0; i < n; i++) exp_mem[int'({hi, lo, 8'(i)})] = wbuf[i];
        // R4: frames 06, 02, then four status polls (three busy, one ready)
        chk(nframes - f0 == 6, "R4 frame count", nframes - f0, 6);
        chk(flog[f0] == 8'h06 && flog[f0 + 1] == 8'h02 && flog[f0 + 5] == 8'h05,
            "R4 opcode order", int'({flog[f0], flog[f0 + 1], flog[f0 + 5]}), 'h060205);
        chk(npoll - p0 == 4, "R4 poll count", npoll - p0, 4);
        chk(last_addr == {hi, lo, 8'h00}, "R2 program address", int'(last_addr),
            int'({hi, lo, 8'h00}));
        check_read(hi, lo, n, "R3 readback");
    endtask

    // ---------------- main ----------------
    initial begin
        int f0;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        chk(spi_cs_n == 1 && spi_sclk == 0, "R1 spi idle", int'({spi_cs_n, spi_sclk}), 'b10);
        chk(busy == 0 && err == 0 && status == 8'h00, "R1 busy/err/status",
            int'({busy, err, status}), 0);

        // R6 broken key stays locked
        reg_write(8'hDA, 8'hAA); reg_write(8'hDA, 8'h55); reg_write(8'hDA, 8'h13);
        reg_write(8'hDA, 8'h50); reg_write(8'hDA, 8'h41); reg_write(8'hDA, 8'h52);
        reg_write(8'hDA, 8'h44);
        chk(status[6] == 0, "R6 broken key", status[6], 0);
        // R6 a breaking 0xaa restarts the match
        reg_write(8'hDA, 8'hAA); reg_write(8'hDA, 8'h55); reg_write(8'hDA, 8'hAA);
        reg_write(8'hDA, 8'h55); reg_write(8'hDA, 8'h50); reg_write(8'hDA, 8'h41);
        reg_write(8'hDA, 8'h52); reg_write(8'hDA, 8'h44);
        chk(status[6] == 1, "R6 restart on 0xaa", status[6], 1);
        // R7 relock
        reg_write(8'hDA, 8'h00);
        chk(status[6] == 0, "R7 relock", status[6], 0);
        // R5 clean key
        send_key();
        chk(status[6] == 1, "R5 unlock", status[6], 1);

        // R3/R4 directed full page and single byte, then random pages
        prog_page(8'h12, 8'h34, 256);
        prog_page(8'h00, 8'hFF, 1);
        for (int k = 0; k < 4; k++)
            prog_page(8'($urandom), 8'($urandom), 1 + int'($urandom_range(0, 255)));
        chk(err == 0, "R3 no error on good bursts", err, 0);

        // R2 short read from the full page
        check_read(8'h12, 8'h34, 3, "R2 short read");

        // R11 phase bits
        chk(seen0 && seen1 && !both && !hi_bits, "R11 status phases",
            int'({seen0, seen1, both, hi_bits}), 'b1100);

        // R9 nonzero offset
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h5A;
        set_page(8'h12, 8'h34);
        f0 = nframes;
        win_burst(8'h05, 4);
        chk(err == 1, "R9 err set", err, 1);
        chk(nframes == f0, "R9 no frame", nframes - f0, 0);
        check_read(8'h12, 8'h34, 4, "R9 flash unchanged");

        // R8 locked burst after reset
        do_reset();
        chk(err == 0 && status[6] == 0, "R1 reset clears err and gate",
            int'({err, status[6]}), 0);
        set_page(8'h12, 8'h34);
        f0 = nframes;
        win_burst(8'h00, 4);
        chk(err == 1, "R8 err set", err, 1);
        chk(nframes == f0, "R8 no frame", nframes - f0, 0);
        repeat (5) @(negedge clk);
        chk(err == 1, "R8 err sticky", err, 1);
        check_read(8'h12, 8'h34, 4, "R8 flash unchanged");

        // R10 SPI hold
        reg_write(8'h82, 8'h20);
        f0 = nframes;
        @(negedge clk); rd_req = 1; rd_len = 8'h03;
        @(negedge clk); rd_req = 0;
        begin
            bit ok = 1;
            for (int i = 0; i < 30; i++) begin
                if (busy || !spi_cs_n) ok = 0;
                @(negedge clk);
            end
            chk(ok && nframes == f0, "R10 held ignores read", nframes - f0, 0);
        end
        reg_write(8'h82, 8'h00);
        check_read(8'h12, 8'h34, 4, "R10 released read");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule